// File: doc/BRIEF.md
# Fractional Resampler Timing Sequencer

This block produces the timing for a fractional-rate resampling stage. Two 48-bit phase accumulators set the rates. The output accumulator adds its frequency word on every clock once running, and its carry marks an output-sample instant. The input accumulator advances only on those carries. Its carry asks for a new input sample, and its upper bits, plus a static offset, give the fractional phase handed to the interpolating filter.

Upstream samples enter an eight-entry elastic buffer at their own rate and leave on read strobes toward the interpolation half-band stage. The accumulators stay idle until the buffer has built up a start-up reserve. Samples are handed over only after a further reset-time depth has accumulated, which sets the group delay; before that the sample port carries zeros. A leap counter clears both accumulators at a programmed interval so that rounding drift cannot build up. A keep-one-in-M counter thins the output strobes, which reaches overall ratios below one.

Top module: `resamp_rate_seq`

## Requirements
- R1: While `nco_run` is high, the output accumulator adds the active output frequency word on every clock modulo 2^48. Its carry appears as an output tick one clock later.
- R2: The input accumulator adds the active input frequency word (mod 2^48) only in clocks that follow an output-accumulator carry. Its carry is registered the same way. `phase_out` is bits [47:39] of (input accumulator + offset term).
- R3: The offset term is `phase_ofs` × 2^40, modulo 2^48, so that one step equals 1/256 of an input-sample period.
- R4: With `leap_len` = L ≠ 0, a cycle counter counts clocks while running. In the clock in which it equals L−1, both accumulators and both carry registers clear to zero at the next edge, and the count restarts from zero. L = 0 disables this.
- R5: `rd_strobe` equals the registered input-accumulator carry when `hb_en` is 0. When `hb_en` is 1, it passes only every other such carry. A toggle that starts at 0 after reset flips on every carry, and the strobe passes when the toggle is 0.
- R6: `nco_run` rises on the clock after the buffer occupancy is first seen at 2 or more, and stays high until reset. While it is low, `out_strobe` and `rd_strobe` stay low.
- R7: `extra_fill` is captured only while `rst_n` is low. Hand-over is enabled on the clock after occupancy is first seen at 2 + `extra_fill` or more. A read strobe before that removes nothing from the buffer. `rd_data` is zero except in a strobe clock in which hand-over is enabled and the buffer is not empty.
- R8: `freq_wr[0]` loads the output word's holding register and `freq_wr[1]` loads the input word's, both from `freq_wdata`. A holding register reaches the active word only on `freq_xfer`, or on `sync_pulse` while `sync_en` is 1. Active words reset to zero.
- R9: `out_strobe` is high on the first of every `dec_m` output ticks, counted from reset. A `dec_m` of 0 acts as 1.
- R10: A write that finds the buffer full with no read in the same clock is dropped and sets `ovf_flag`. A hand-over strobe that finds the buffer empty sets `unf_flag`. Both flags stay set until reset.
- R11: Samples leave the buffer in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream sample present this clock |
| in_data | input | 16 | Upstream sample |
| freq_wr | input | 2 | Holding-register load strobes (bit 0 output word, bit 1 input word) |
| freq_wdata | input | 48 | Frequency word to load |
| freq_xfer | input | 1 | Move both holding registers into the active words |
| sync_pulse | input | 1 | System sync pulse |
| sync_en | input | 1 | Lets `sync_pulse` move the holding registers |
| phase_ofs | input | 9 | Static phase offset in 1/256 input periods |
| extra_fill | input | 2 | Extra start-up depth, captured during reset |
| hb_en | input | 1 | Half-band stage present: read on every other carry |
| leap_len | input | 32 | Realignment interval in clocks, 0 = off |
| dec_m | input | 8 | Keep one output tick in this many |
| rd_strobe | output | 1 | Read strobe toward the half-band stage |
| rd_data | output | 16 | Sample handed over, zero-forced |
| phase_out | output | 9 | Fractional phase for the interpolating filter |
| out_strobe | output | 1 | Output sample strobe after decimation |
| nco_run | output | 1 | Accumulators running |
| ovf_flag | output | 1 | Sticky buffer overflow |
| unf_flag | output | 1 | Sticky buffer underflow |

## Verification
The bench builds the block with its defaults: 48-bit accumulators, an eight-deep buffer, a 32-bit leap counter and an 8-bit keep count. It picks frequency words that are exact binary fractions, so carries come every few clocks and cycle-exact comparison against a behavioural model stays readable. It then switches to non-binary words, where carries jitter and the leap interval of 37 clocks cuts across them. It runs two reset epochs with different extra depths, and it starves and floods the buffer, which brings the priming threshold, both sticky flags and hand-over ordering within reach in about fifteen hundred clocks.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned NUM_NCO = 2;
  localparam int unsigned NCO_OUT = 0;  // output-rate accumulator
  localparam int unsigned NCO_IN  = 1;  // input-consumption accumulator
endpackage

// File: rtl/rrs_phase_acc.sv
module rrs_phase_acc #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] inc,
  output logic [W-1:0] acc,
  output logic         carry
);
  logic [W:0]   sum;
  logic [W-1:0] acc_d;
  logic         cy_d;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, inc};
    acc_d = acc;
    cy_d  = 1'b0;
    if (clr) begin
      acc_d = '0;
    end else if (adv) begin
      acc_d = sum[W-1:0];
      cy_d  = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      acc   <= acc_d;
      carry <= cy_d;
    end
  end

  // R4: a clear leaves a zero phase and no carry
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !carry));
  // R2: without advance the phase holds and no carry appears
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> ($stable(acc) && !carry));
endmodule

// File: rtl/rrs_elastic_fifo.sv
module rrs_elastic_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [$clog2(DEPTH):0] count,
  output logic          ovf_flag,
  output logic          unf_flag
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_d;
  logic          empty, full, pop_ok, push_ok;
  logic          ovf_d, unf_d;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push_ok) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    cnt_d = count + CW'(push_ok) - CW'(pop_ok);
    ovf_d = ovf_flag | (push && !push_ok);
    unf_d = unf_flag | (pop_req && empty);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      count    <= cnt_d;
      ovf_flag <= ovf_d;
      unf_flag <= unf_d;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
endmodule

// File: rtl/rrs_dbl_word.sv
module rrs_dbl_word #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_wr,
  input  logic [W-1:0] wdata,
  input  logic         commit,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q, hold_d, act_d;

  always_comb begin
    hold_d = hold_wr ? wdata : hold_q;
    act_d  = commit ? hold_q : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      active <= '0;
    end else begin
      hold_q <= hold_d;
      active <= act_d;
    end
  end

  // R8: the active word moves only on a commit
  a_r8_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
endmodule

// File: rtl/resamp_rate_seq.sv
module resamp_rate_seq
  import rrs_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned ACC_W      = 48,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LEAP_W     = 32,
  parameter int unsigned DEC_W      = 8,
  parameter int unsigned PH_W       = 9,
  parameter int unsigned OFS_W      = 9,
  parameter int unsigned EXTRA_W    = 2,
  parameter int unsigned START_FILL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_data,
  input  logic [NUM_NCO-1:0] freq_wr,
  input  logic [ACC_W-1:0]   freq_wdata,
  input  logic               freq_xfer,
  input  logic               sync_pulse,
  input  logic               sync_en,
  input  logic [OFS_W-1:0]   phase_ofs,
  input  logic [EXTRA_W-1:0] extra_fill,
  input  logic               hb_en,
  input  logic [LEAP_W-1:0]  leap_len,
  input  logic [DEC_W-1:0]   dec_m,
  output logic               rd_strobe,
  output logic [DW-1:0]      rd_data,
  output logic [PH_W-1:0]    phase_out,
  output logic               out_strobe,
  output logic               nco_run,
  output logic               ovf_flag,
  output logic               unf_flag
);
  localparam int unsigned CW     = $clog2(DEPTH) + 1;
  localparam int unsigned FRAC_W = OFS_W - 1;          // offset steps per period = 2^FRAC_W
  localparam int unsigned OFS_SH = ACC_W - FRAC_W;

  // ---------------- frequency words ----------------
  logic             commit;
  logic [ACC_W-1:0] act_word [NUM_NCO];

  assign commit = freq_xfer | (sync_pulse & sync_en);

  for (genvar g = 0; g < NUM_NCO; g++) begin : g_word
    rrs_dbl_word #(.W(ACC_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_wr (freq_wr[g]),
      .wdata   (freq_wdata),
      .commit  (commit),
      .active  (act_word[g])
    );
  end

  // ---------------- control state ----------------
  logic               primed_q, primed_d, run_d;
  logic [EXTRA_W-1:0] extra_q;
  logic [LEAP_W-1:0]  lc_q, lc_d;
  logic [DEC_W-1:0]   dcnt_q, dcnt_d, dcnt_inc, m_eff;
  logic               tog_q, tog_d;
  logic               leap_hit;
  logic [CW-1:0]      fill, prime_lvl;

  logic [ACC_W-1:0]   acc_out, acc_in, ofs_term, ph_sum;
  logic               cy_out, cy_in;
  logic               take;
  logic [DW-1:0]      head;

  assign prime_lvl = CW'(START_FILL) + CW'(extra_q);
  assign leap_hit  = nco_run && (leap_len != '0) && (lc_q == leap_len - 1'b1);
  assign m_eff     = (dec_m == '0) ? DEC_W'(1) : dec_m;
  assign dcnt_inc  = dcnt_q + 1'b1;

  always_comb begin
    run_d    = nco_run  | (fill >= CW'(START_FILL));
    primed_d = primed_q | (fill >= prime_lvl);
    if (!nco_run || leap_hit) lc_d = '0;
    else                      lc_d = lc_q + 1'b1;
    dcnt_d = dcnt_q;
    if (cy_out) dcnt_d = (dcnt_inc >= m_eff) ? '0 : dcnt_inc;
    tog_d = tog_q ^ cy_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nco_run  <= 1'b0;
      primed_q <= 1'b0;
      lc_q     <= '0;
      dcnt_q   <= '0;
      tog_q    <= 1'b0;
    end else begin
      nco_run  <= run_d;
      primed_q <= primed_d;
      lc_q     <= lc_d;
      dcnt_q   <= dcnt_d;
      tog_q    <= tog_d;
    end
  end

  // extra depth is sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) extra_q <= extra_fill;
  end

  // ---------------- accumulators ----------------
  rrs_phase_acc #(.W(ACC_W)) u_acc_out (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (leap_hit),
    .adv   (nco_run),
    .inc   (act_word[NCO_OUT]),
    .acc   (acc_out),
    .carry (cy_out)
  );

  rrs_phase_acc #(.W(ACC_W)) u_acc_in (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (leap_hit),
    .adv   (cy_out),
    .inc   (act_word[NCO_IN]),
    .acc   (acc_in),
    .carry (cy_in)
  );

  assign ofs_term  = {phase_ofs[FRAC_W-1:0], {OFS_SH{1'b0}}};
  assign ph_sum    = acc_in + ofs_term;
  assign phase_out = ph_sum[ACC_W-1 -: PH_W];

  // ---------------- strobes and data ----------------
  assign out_strobe = cy_out && (dcnt_q == '0);
  assign rd_strobe  = cy_in && (!hb_en || !tog_q);
  assign take       = rd_strobe && primed_q;
  assign rd_data    = (take && fill != '0) ? head : '0;

  rrs_elastic_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (in_valid),
    .wdata    (in_data),
    .pop_req  (take),
    .head     (head),
    .count    (fill),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
  );

  a_r6_quiet_until_run: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_run |-> (!out_strobe && !rd_strobe));
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nco_run |=> nco_run);
  a_r7_zero_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (rd_data == '0));
  a_r5_hb_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_en && rd_strobe) |=> !tog_q || !cy_in || !rd_strobe);
endmodule

// File: tb/resamp_rate_seq_tb.sv
module resamp_rate_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [1:0]  freq_wr;
  logic [47:0] freq_wdata;
  logic        freq_xfer, sync_pulse, sync_en;
  logic [8:0]  phase_ofs;
  logic [1:0]  extra_fill;
  logic        hb_en;
  logic [31:0] leap_len;
  logic [7:0]  dec_m;
  logic        rd_strobe, out_strobe, nco_run, ovf_flag, unf_flag;
  logic [15:0] rd_data;
  logic [8:0]  phase_out;

  always #5 clk = ~clk;

  resamp_rate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .freq_wr(freq_wr), .freq_wdata(freq_wdata), .freq_xfer(freq_xfer),
    .sync_pulse(sync_pulse), .sync_en(sync_en), .phase_ofs(phase_ofs),
    .extra_fill(extra_fill), .hb_en(hb_en), .leap_len(leap_len), .dec_m(dec_m),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .phase_out(phase_out),
    .out_strobe(out_strobe), .nco_run(nco_run), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string ptag = "reset";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t actual %h expected %h", tag, ptag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit [15:0] q[$];
  bit [47:0] m_acc1, m_acc2, m_act1, m_act2, m_hold1, m_hold2;
  bit        m_c1, m_c2, m_run, m_primed, m_tog, m_ovf, m_unf;
  int unsigned m_lc, m_dcnt, m_extra;

  function automatic bit m_rd();
    return m_c2 && (!hb_en || !m_tog);
  endfunction

  always @(posedge clk) begin
    int unsigned sz, mm;
    bit rd, take, pop, leap, commit;
    bit [48:0] s1, s2;
    if (!rst_n) begin
      m_extra = extra_fill;
      m_acc1 = 0; m_acc2 = 0; m_act1 = 0; m_act2 = 0; m_hold1 = 0; m_hold2 = 0;
      m_c1 = 0; m_c2 = 0; m_run = 0; m_primed = 0; m_tog = 0; m_ovf = 0; m_unf = 0;
      m_lc = 0; m_dcnt = 0;
      q.delete();
    end else begin
      sz   = q.size();
      rd   = m_rd();
      take = rd && m_primed;
      pop  = take && sz > 0;
      if (take && sz == 0) m_unf = 1;
      if (pop) void'(q.pop_front());
      if (in_valid) begin
        if (sz < 8 || pop) q.push_back(in_data);
        else m_ovf = 1;
      end
      leap = m_run && leap_len != 0 && m_lc == leap_len - 32'd1;
      s1 = {1'b0, m_acc1} + {1'b0, m_act1};
      s2 = {1'b0, m_acc2} + {1'b0, m_act2};
      mm = (dec_m == 0) ? 1 : dec_m;
      if (m_c1) m_dcnt = (m_dcnt + 1 >= mm) ? 0 : m_dcnt + 1;
      if (m_c2) m_tog = !m_tog;
      if (leap) begin
        m_acc2 = 0; m_c2 = 0;
      end else if (m_c1) begin
        m_acc2 = s2[47:0]; m_c2 = s2[48];
      end else m_c2 = 0;
      if (leap) begin
        m_acc1 = 0; m_c1 = 0;
      end else if (m_run) begin
        m_acc1 = s1[47:0]; m_c1 = s1[48];
      end else m_c1 = 0;
      m_lc = (!m_run || leap) ? 0 : m_lc + 1;
      if (sz >= 2) m_run = 1;
      if (sz >= 2 + m_extra) m_primed = 1;
      commit = freq_xfer || (sync_pulse && sync_en);
      if (commit) begin m_act1 = m_hold1; m_act2 = m_hold2; end
      if (freq_wr[0]) m_hold1 = freq_wdata;
      if (freq_wr[1]) m_hold2 = freq_wdata;
    end
  end

  task automatic compare();
    bit [47:0] t;
    bit        rd;
    bit [15:0] d;
    rd = m_rd();
    d  = (rd && m_primed && q.size() > 0) ? q[0] : 16'h0;
    t  = m_acc2 + (48'(phase_ofs) << 40);
    chk("R1/R9 out_strobe", 64'(out_strobe), 64'(m_c1 && m_dcnt == 0));
    chk("R5 rd_strobe",     64'(rd_strobe),  64'(rd));
    chk("R7/R11 rd_data",   64'(rd_data),    64'(d));
    chk("R2/R3 phase_out",  64'(phase_out),  64'(t[47:39]));
    chk("R6 nco_run",       64'(nco_run),    64'(m_run));
    chk("R10 ovf_flag",     64'(ovf_flag),   64'(m_ovf));
    chk("R10 unf_flag",     64'(unf_flag),   64'(m_unf));
  endtask

  // ---------------- stimulus ----------------
  int        wr_period = 0;
  int        cyc = 0;
  bit [15:0] wval = 0;
  bit [1:0]  pend_wr = 0;
  bit [47:0] pend_data = 0;
  bit        pend_xfer = 0, pend_sync = 0;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare();
      cyc++;
      in_valid = (wr_period != 0) && (cyc % wr_period == 0);
      if (in_valid) wval = wval + 16'h0101;
      in_data    = wval;
      freq_wr    = pend_wr;
      freq_wdata = pend_data;
      freq_xfer  = pend_xfer;
      sync_pulse = pend_sync;
      pend_wr = 0; pend_xfer = 0; pend_sync = 0;
    end
  endtask

  task automatic load(input int idx, input bit [47:0] v);
    pend_wr = 2'(1 << idx); pend_data = v;
    step(1);
  endtask

  task automatic do_reset(input bit [1:0] e);
    @(negedge clk);
    rst_n = 0; extra_fill = e; in_valid = 0; wr_period = 0;
    freq_wr = 0; freq_xfer = 0; sync_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R6 reset nco_run",     64'(nco_run), 0);
    chk("R1 reset out_strobe",  64'(out_strobe), 0);
    chk("R5 reset rd_strobe",   64'(rd_strobe), 0);
    chk("R10 reset ovf_flag",   64'(ovf_flag), 0);
    chk("R10 reset unf_flag",   64'(unf_flag), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; freq_wr = 0; freq_wdata = 0;
    freq_xfer = 0; sync_pulse = 0; sync_en = 0; phase_ofs = 9'd3;
    extra_fill = 2; hb_en = 0; leap_len = 0; dec_m = 1;

    // epoch 1: binary rates, priming with extra depth 2 (R7)
    do_reset(2);
    ptag = "R1 R2 R3 R7 R11 binary rates";
    load(0, 48'h4000_0000_0000);
    load(1, 48'h8000_0000_0000);
    pend_xfer = 1; step(1);
    wr_period = 8;
    step(400);

    // held word without commit, then commit by sync (R8); half-band and keep-one-in-3 (R5 R9)
    ptag = "R8 R5 R9 held word and sync commit";
    hb_en = 1; dec_m = 3; phase_ofs = 9'd300; wr_period = 24;
    load(0, 48'h2AAA_AAAA_AAAB);
    step(50);
    sync_pulse = 0; sync_en = 1; pend_sync = 1; step(1);
    sync_en = 0;
    step(400);

    // leap realignment with non-binary input word (R4)
    ptag = "R4 leap interval";
    hb_en = 0; dec_m = 1; leap_len = 37; wr_period = 10; phase_ofs = 9'd511;
    load(1, 48'h5555_5555_5555);
    pend_xfer = 1; step(1);
    step(400);

    // starve the buffer (R10)
    ptag = "R10 starvation";
    leap_len = 0; wr_period = 0;
    step(200);
    chk("R10 underflow seen", 64'(unf_flag), 1);

    // epoch 2: extra depth 0, idle accumulators, flood the buffer (R10 R6)
    do_reset(0);
    ptag = "R10 R6 flood";
    wr_period = 1;
    step(12);
    wr_period = 0;
    step(5);
    chk("R10 overflow seen", 64'(ovf_flag), 1);
    chk("R6 running after fill", 64'(nco_run), 1);
    chk("R1 no tick with zero word", 64'(out_strobe), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule